// File: doc/BRIEF.md
# Reconfigurable Table Memory

This block holds a 64-bit lookup-table store and uses it as small writable memory. The store has four one-bit lanes of sixteen cells each. A two-bit mode input decides how the lanes are addressed and written. In the split mode, the store becomes two independent 16x2 memories. In the wide mode, it becomes one 16x4 single-port memory. In the dual-port mode, it becomes one 16x2 memory with separate write and read addresses.

A 4-bit data bus supplies the write data. One enable input acts as the write strobe. Two 4-bit address buses, `addrA` and `addrB`, supply the addresses. Reads are combinational in every mode. Stored values change only at a rising clock edge.

The contents are not cleared when the mode changes. A word written in one mode can be read back in another mode through the fixed lane mapping given below.

Top module: `lutRam`

## Requirements
- R1: While `rstN` is low, every cell is cleared at the clock edge. After reset, every mode with `wrEn` low reads 0 at every address.
- R2: In mode 1 (wide, 16x4), a rising edge with `wrEn` high stores `wrData[k]` into lane k at row `addrA`, for all four lanes. `rdData[k]` always shows lane k at row `addrA`.
- R3: In mode 1, a read of the row being written returns the old word until the edge.
- R4: In mode 0 (split), the lower half works as one memory and the upper half as another. Lanes 0 and 1 use `addrA` and the data bits `wrData[1:0]`. Lanes 2 and 3 use `addrB` and the data bits `wrData[3:2]`. `rdData[k]` shows lane k at its own half's address.
- R5: In mode 0, while `wrEn` is high, `rdData` equals `wrData` combinationally. The value is retained by the clock edge that sees `wrEn` high.
- R6: In mode 2 (dual-port, 16x2), an edge with `wrEn` high writes `wrData[1:0]` at row `addrA` into both copies: lanes 0-1 and lanes 2-3. `rdData[1:0]` shows lanes 0-1 at `addrA`. `rdData[3:2]` shows lanes 2-3 at `addrB`.
- R7: In mode 2, a read through `addrB` of the row being written returns the old data until the edge.
- R8: With `wrEn` low, no cell changes in any mode.
- R9: Mode 3 is reserved. It never writes, and it reads like mode 1.
- R10: Storage is shared across modes. Lane k, row r holds the same bit whichever mode wrote it or reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rstN | input | 1 | Active-low synchronous clear of all cells |
| mode | input | 2 | 0 split 2x(16x2), 1 wide 16x4, 2 dual-port 16x2, 3 reserved |
| wrEn | input | 1 | Write enable |
| wrData | input | 4 | Write data |
| addrA | input | 4 | Lower-half / wide / write address |
| addrB | input | 4 | Upper-half / read address |
| rdData | output | 4 | Combinational read data |

## Verification
The hold and readback properties assume the following. After a write, the inputs that a property compares have either stayed the same or have changed visibly. A change of mode or address between two cycles only relaxes a check; it never falsifies one. The stimulus changes every input only at the falling edge and keeps `wrEn` low during reset. This means each property sees one settled input set per clock cycle. Address sweeps walk both buses over all sixteen rows, so the same-address and cross-address cases of the split and dual-port modes both occur.

// File: rtl/lutRamPkg.sv
package lutRamPkg;
  localparam int ADDR_W = 4;
  localparam int LANES  = 4;
  localparam int HALF   = LANES / 2;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_WIDE  = 2'd1,
    MODE_DUAL  = 2'd2,
    MODE_RSVD  = 2'd3
  } memMode_e;

  // Per-lane strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] laneWr;   // write this lane at the edge
    logic [LANES-1:0] wrUseB;   // write address from bus B
    logic [LANES-1:0] rdUseB;   // read address from bus B
    logic [LANES-1:0] dataFold; // take data from the lower half of the bus
    logic [LANES-1:0] passThru; // show write data on the read port
  } laneCtrl_t;
endpackage

// File: rtl/lutRamCtrl.sv
module lutRamCtrl
  import lutRamPkg::*;
(
  input  memMode_e  mode,
  input  logic      wrEn,
  output laneCtrl_t ctl
);
  localparam logic [LANES-1:0] UPPER = {{HALF{1'b1}}, {HALF{1'b0}}};

  always_comb begin
    ctl = '0;
    unique case (mode)
      MODE_SPLIT: begin
        ctl.laneWr   = {LANES{wrEn}};
        ctl.wrUseB   = UPPER;
        ctl.rdUseB   = UPPER;
        ctl.passThru = {LANES{wrEn}};
      end
      MODE_WIDE: begin
        ctl.laneWr = {LANES{wrEn}};
      end
      MODE_DUAL: begin
        ctl.laneWr   = {LANES{wrEn}};
        ctl.rdUseB   = UPPER;
        ctl.dataFold = UPPER;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/lutRamLanes.sv
module lutRamLanes
  import lutRamPkg::*;
#(
  parameter int ADDR_W = lutRamPkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneCtrl_t         ctl,
  input  logic [LANES-1:0]  wrData,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  output logic [LANES-1:0]  rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar k = 0; k < LANES; k++) begin : gLane
    logic [DEPTH-1:0]  cells;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
    logic              dIn;

    assign wrAddr = ctl.wrUseB[k] ? addrB : addrA;
    assign rdAddr = ctl.rdUseB[k] ? addrB : addrA;
    assign dIn    = ctl.dataFold[k] ? wrData[k % HALF] : wrData[k];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cells <= '0;
      end else if (ctl.laneWr[k]) begin
        cells[wrAddr] <= dIn;
      end
    end

    assign rdData[k] = ctl.passThru[k] ? dIn : cells[rdAddr];
  end
endmodule

// File: rtl/lutRam.sv
module lutRam
  import lutRamPkg::*;
#(
  parameter int ADDR_W = lutRamPkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              wrEn,
  input  logic [LANES-1:0]  wrData,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  output logic [LANES-1:0]  rdData
);
  laneCtrl_t ctl;

  lutRamCtrl u_ctrl (
    .mode (memMode_e'(mode)),
    .wrEn (wrEn),
    .ctl  (ctl)
  );

  lutRamLanes #(.ADDR_W(ADDR_W)) u_lanes (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wrData (wrData),
    .addrA  (addrA),
    .addrB  (addrB),
    .rdData (rdData)
  );
endmodule

// File: rtl/lutRamChk.sv
module lutRamChk #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        mode,
  input logic              wrEn,
  input logic [LANES-1:0]  wrData,
  input logic [ADDR_W-1:0] addrA,
  input logic [ADDR_W-1:0] addrB,
  input logic [LANES-1:0]  rdData
);
  localparam int HALF = LANES / 2;

  // R1: a cleared store reads zero unless split-mode pass-through is active
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> ((wrEn && mode == 2'd0) || rdData == '0));

  assert_wide_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && wrEn) |=>
      (mode != 2'd1 || !$stable(addrA) || rdData == $past(wrData)));

  assert_split_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && wrEn) |-> rdData == wrData);

  assert_split_keep_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && wrEn) |=>
      (wrEn || !$stable(mode) || !$stable(addrA) || !$stable(addrB) ||
       rdData == $past(wrData)));

  assert_dual_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && wrEn) |=>
      (mode != 2'd2 || !$stable(addrA) ||
       rdData[HALF-1:0] == $past(wrData[HALF-1:0])));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (wrEn || !$stable(mode) || !$stable(addrA) ||
               !$stable(addrB) || $stable(rdData)));

  assert_rsvd_nowrite_R9: assert property (@(posedge clk) disable iff (!rstN)
    mode == 2'd3 |=> (!$stable(mode) || !$stable(addrA) || $stable(rdData)));
endmodule

bind lutRam lutRamChk #(.ADDR_W(ADDR_W), .LANES(lutRamPkg::LANES)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .mode   (mode),
  .wrEn   (wrEn),
  .wrData (wrData),
  .addrA  (addrA),
  .addrB  (addrB),
  .rdData (rdData)
);

// File: tb/lutRam_tb.sv
`timescale 1ns/1ps
module lutRam_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'd1;
  logic       wrEn = 1'b0;
  logic [3:0] wrData = 4'd0;
  logic [3:0] addrA = 4'd0;
  logic [3:0] addrB = 4'd0;
  logic [3:0] rdData;

  int errors = 0;
  int checks = 0;
  bit refMem [4][16];

  always #4 clk = ~clk;

  lutRam u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .wrEn(wrEn),
    .wrData(wrData), .addrA(addrA), .addrB(addrB), .rdData(rdData)
  );

  function automatic logic [3:0] expRead(input logic [1:0] m, input logic e,
                                         input logic [3:0] d, input logic [3:0] a,
                                         input logic [3:0] b);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) begin
      if (m == 2'd0) r[k] = e ? d[k] : refMem[k][(k < 2) ? a : b];
      else if (m == 2'd2) r[k] = refMem[k][(k < 2) ? a : b];
      else r[k] = refMem[k][a];
    end
    return r;
  endfunction

  function automatic void modelWrite(input logic [1:0] m, input logic [3:0] d,
                                     input logic [3:0] a, input logic [3:0] b);
    for (int k = 0; k < 4; k++) begin
      if (m == 2'd0) refMem[k][(k < 2) ? a : b] = d[k];
      else if (m == 2'd1) refMem[k][a] = d[k];
      else if (m == 2'd2) refMem[k][a] = d[k % 2];
    end
  endfunction

  task automatic step(input logic [1:0] m, input logic e, input logic [3:0] d,
                      input logic [3:0] a, input logic [3:0] b, input string tag);
    logic [3:0] exp;
    @(negedge clk);
    mode = m; wrEn = e; wrData = d; addrA = a; addrB = b;
    #1;
    exp = expRead(m, e, d, a, b);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s: mode=%0d en=%0d a=%0d b=%0d got %h expected %h",
               tag, m, e, a, b, rdData, exp);
    end
    @(posedge clk);
    if (e && rstN) modelWrite(m, d, a, b);
  endtask

  task automatic sweep(input logic [1:0] m, input string tag);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        step(m, 1'b0, 4'hF, 4'(a), 4'(b), tag);
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish();
  end

  initial begin
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 16; r++)
        refMem[k][r] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: cleared store in every mode
    for (int m = 0; m < 4; m++) sweep(2'(m), "R1");

    // R3: wide writes, old word visible before the edge
    for (int a = 0; a < 16; a++) step(2'd1, 1'b1, 4'((a * 7 + 3) & 15), 4'(a), 4'(15 - a), "R3");
    // R2: wide readback
    for (int a = 0; a < 16; a++) step(2'd1, 1'b0, 4'h0, 4'(a), 4'(a), "R2");

    // R8: enable low never writes, in every mode
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 16; a++) step(2'(m), 1'b0, ~4'(a), 4'(a), 4'(a ^ 5), "R8");
    sweep(2'd1, "R8");

    // R10: words written in wide mode read through split and dual mappings
    sweep(2'd0, "R10");
    sweep(2'd2, "R10");

    // R5: split writes with pass-through; R4: independent halves
    for (int a = 0; a < 16; a++) step(2'd0, 1'b1, 4'((a * 5 + 9) & 15), 4'(a), 4'((a * 3) & 15), "R5");
    sweep(2'd0, "R4");

    // R7: dual-port write read at same row returns old data until the edge
    for (int a = 0; a < 16; a++) step(2'd2, 1'b1, 4'((a * 11 + 1) & 15), 4'(a), 4'(a), "R7");
    for (int a = 0; a < 16; a++) step(2'd2, 1'b1, 4'((a * 13 + 6) & 15), 4'(a), 4'(15 - a), "R6");
    sweep(2'd2, "R6");

    // R9: reserved mode ignores enable and reads like wide mode
    for (int a = 0; a < 16; a++) step(2'd3, 1'b1, ~4'(a * 3), 4'(a), 4'(a), "R9");
    sweep(2'd3, "R9");
    sweep(2'd1, "R9");

    // R1: reset again after activity
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); @(posedge clk);
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 16; r++)
        refMem[k][r] = 1'b0;
    @(negedge clk); rstN = 1'b1;
    sweep(2'd1, "R1");
    sweep(2'd0, "R1");

    finish();
  end
endmodule